// File: doc/BRIEF.md
# Single-Word MDIO Management Controller

This block is a clause-22 management-interface master that software drives through one 32-bit command and status word. One store carries everything a transaction needs: a start flag, a direction flag, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. The block then generates MDC from the system clock and shifts a complete 64-bit management frame out on MDIO. It drives MDIO through a separate output-enable so that the pad can be shared with the PHY.

The start flag also serves as the busy flag. It reads back as one for as long as the frame runs and drops when the last bit has gone out. For a read, the 16 bits returned by the PHY replace the low half of the word at the moment the flag drops. Software polls the word until the flag is clear and only then takes the result or issues the next command. The block ignores a store that arrives while a frame is in flight.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000_0000, MDC is low and MDIO is not driven.
- R2: A store with bit 31 set, made while bit 31 reads 0, starts a frame. Bit 31 then reads 1 from the next cycle for exactly 64 MDC periods (128 x MDC_HALF_DIV clocks) and then reads 0. Bit 31 can rise only through such a store.
- R3: The frame sends, MSB first, these fields: 32 ones; start bits 0,1; opcode 1,0 when bit 30 is set (read) or 0,1 when bit 30 is clear (write); the PHY address from bits 25:21; the register number from bits 20:16; two turnaround bits; and 16 data bits.
- R4: In a write frame the block drives the turnaround as 1,0 and then sends bits 15:0 of the command as the data.
- R5: In a read frame the block releases MDIO from the first turnaround bit to the end of the frame. It samples MDIO on the 16 rising MDC edges of the data field, MSB first. When bit 31 drops, the sampled value appears in bits 15:0, while bits 30:16 keep their command values.
- R6: MDC has a period of 2 x MDC_HALF_DIV system clocks, gives exactly 64 rising edges per frame and stays low when idle. While driven, MDIO changes only on a falling MDC edge.
- R7: A store made while bit 31 reads 1 has no effect. This includes a store in the cycle in which the frame completes: the frame, the command fields and the read result stay unchanged and no new frame starts.
- R8: A store with bit 31 clear, made while idle, is kept verbatim in the status word and starts no frame.
- R9: MDIO output-enable is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store strobe for the command word |
| wr_data | input | 32 | Command word to store |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable, high while the block drives |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
Two events can fall in the same cycle: a software store and the completion of the frame, which clears the busy flag and loads the read result. The bench places a store on the exact clock edge at which the last falling MDC edge ends a frame, and a second store partway through a read frame. It then judges R7 at the ports. The frame captured by the PHY model and the final status word must equal what the original command alone predicts, and the MDC rising-edge count must not grow over the following idle stretch.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    // Field positions inside the command/status word
    localparam int REQ_BIT   = 31;
    localparam int RD_BIT    = 30;
    localparam int ADDR_W    = 5;
    localparam int PHY_LSB   = 21;
    localparam int REG_LSB   = 16;
    localparam int DATA_W    = 16;
    localparam int WORD_W    = 32;

    // Frame geometry
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = FRAME_LEN - DATA_W - 2;   // first turnaround bit
    localparam int DAT_POS   = FRAME_LEN - DATA_W;       // first data bit

    typedef struct packed {
        logic                 active;
        logic                 is_rd;
        logic [FRAME_LEN-1:0] sreg;
        logic [IDX_W-1:0]     idx;
        logic [DATA_W-1:0]    cap;
    } shift_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
    } ctrl_st_t;

    // Assemble the full frame image, MSB sent first
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [WORD_W-2:0] w);
        logic [FRAME_LEN-1:0] f;
        logic                 rd;
        rd = w[RD_BIT];
        f  = {
            {PRE_LEN{1'b1}},
            2'b01,
            (rd ? 2'b10 : 2'b01),
            w[PHY_LSB +: ADDR_W],
            w[REG_LSB +: ADDR_W],
            (rd ? 2'b11 : 2'b10),
            (rd ? {DATA_W{1'b0}} : w[DATA_W-1:0])
        };
        return f;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } mdc_st_t;

    mdc_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d     = st_q;
        term     = (st_q.cnt == CW'(HALF_DIV - 1));
        rise_stb = run && term && !st_q.mdc;
        fall_stb = run && term && st_q.mdc;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (term) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-2:0] cmd_word,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
            st_d.is_rd  = cmd_word[RD_BIT];
            st_d.sreg   = build_frame(cmd_word);
            st_d.idx    = '0;
            st_d.cap    = '0;
        end else if (st_q.active) begin
            // PHY data is sampled while MDC rises
            if (rise_stb && (st_q.idx >= IDX_W'(DAT_POS))) begin
                st_d.cap = {st_q.cap[DATA_W-2:0], mdio_i};
            end
            // Next bit is presented while MDC falls
            if (fall_stb) begin
                if (st_q.idx == IDX_W'(FRAME_LEN - 1)) begin
                    st_d.active = 1'b0;
                    done        = 1'b1;
                end else begin
                    st_d.idx  = st_q.idx + IDX_W'(1);
                    st_d.sreg = {st_q.sreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdio_o  = st_q.active & st_q.sreg[FRAME_LEN-1];
    assign mdio_oe = st_q.active && (!st_q.is_rd || (st_q.idx < IDX_W'(TA_POS)));
    assign rd_word = st_q.cap;

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    ctrl_st_t          st_d, st_q;
    logic              busy;
    logic              start;
    logic              done;
    logic              rise_stb;
    logic              fall_stb;
    logic [DATA_W-1:0] rd_word;

    assign busy = st_q.cmd[REQ_BIT];

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (wr_en && !busy) begin
            st_d.cmd = wr_data;
            start    = wr_data[REQ_BIT];
        end
        if (done) begin
            st_d.cmd[REQ_BIT] = 1'b0;
            if (st_q.cmd[RD_BIT]) begin
                st_d.cmd[DATA_W-1:0] = rd_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mdio_mdc_gen #(
        .HALF_DIV (MDC_HALF_DIV)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd_word (wr_data[WORD_W-2:0]),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_word  (rd_word)
    );

    assign rd_data = st_q.cmd;

endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        mdio_i
);
    logic busy;
    assign busy = rd_data[31];

    // R9 / R6: nothing toggles or drives outside a frame
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R6: a driven MDIO moves only on a falling MDC edge
    assert_mdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

    // R7: command fields hold while a frame runs
    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_data[30:16]));

    // R2: busy rises only after a store carrying the request bit
    assert_start_by_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_data[31]));

    // R9: the enable never rises without a frame in flight
    assert_oe_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> busy);

    logic unused_in;
    assign unused_in = mdio_i;

endmodule

bind mdio_cmd_ctrl mdio_cmd_chk u_chk (.*);

// File: tb/sim_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_cmd_ctrl;
    localparam int HALF       = 2;
    localparam int FRAME_CLKS = 64 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_cmd_ctrl #(.MDC_HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- PHY model ----------------
    int          total_rises = 0;
    int          base = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] reply = '0;

    always @(posedge mdc) begin
        if ((total_rises - base) < 64 && (total_rises - base) >= 0) begin
            cap_bits[63 - (total_rises - base)] = mdio_o;
            cap_oe[63 - (total_rises - base)]   = mdio_oe;
        end
        total_rises++;
    end

    always @(negedge mdc) begin
        if ((total_rises - base) >= 48 && (total_rises - base) < 64)
            mdio_i = reply[63 - (total_rises - base)];
        else
            mdio_i = 1'b1;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        logic [31:0] word;
        int          clks;
    } exp_t;
    exp_t sbq[$];

    function automatic exp_t predict(input logic [31:0] cmd, input logic [15:0] phy_val);
        exp_t e;
        logic rd;
        rd     = cmd[30];
        e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), cmd[25:21], cmd[20:16],
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : cmd[15:0])};
        e.oe   = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        e.word = rd ? {1'b0, cmd[30:16], phy_val} : {1'b0, cmd[30:0]};
        e.clks = FRAME_CLKS;
        return e;
    endfunction

    // monitor: pops one expectation each time busy falls
    initial begin
        logic busy_prev;
        int   busy_clks;
        exp_t e;
        busy_prev = 1'b0;
        busy_clks = 0;
        forever begin
            @(negedge clk);
            if (rd_data[31]) busy_clks++;
            if (busy_prev && !rd_data[31]) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2 unexpected frame", 64'(rd_data), 64'h0);
                end else begin
                    e = sbq.pop_front();
                    check(((cap_bits ^ e.bits) & e.oe) == 64'h0, "R3 frame bits", cap_bits, e.bits);
                    check(cap_oe == e.oe, "R5/R9 drive mask", cap_oe, e.oe);
                    check(rd_data == e.word, "R4/R5 final word", 64'(rd_data), 64'(e.word));
                    check(busy_clks == e.clks, "R2 busy length", 64'(busy_clks), 64'(e.clks));
                    check((total_rises - base) == 64, "R6 rising edges", 64'(total_rises - base), 64'd64);
                end
                busy_clks = 0;
            end
            busy_prev = rd_data[31];
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [31:0] cmd, input logic [15:0] phy_val);
        @(negedge clk);
        reply   = phy_val;
        base    = total_rises;
        sbq.push_back(predict(cmd, phy_val));
        wr_en   = 1'b1;
        wr_data = cmd;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit req, input bit rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
        return {req, rd, 4'b0, phy, rg, d};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        realtime t1, t2;
        int r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0, "R1 word", 64'(rd_data), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 64'h0);

        // R8 idle store without request bit
        @(negedge clk);
        r0 = total_rises;
        wr_en = 1'b1; wr_data = 32'h3456_789A;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        check(rd_data == 32'h3456_789A, "R8 stored word", 64'(rd_data), 64'h3456_789A);
        check(total_rises == r0 && !mdio_oe, "R8 no frame", 64'(total_rises - r0), 64'h0);

        // R3/R4 write frame; also measure MDC period (R6)
        issue(mk(1, 0, 5'h11, 5'h04, 16'hBEEF), 16'h0);
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        check((t2 - t1) == 2.0 * HALF * 5.0, "R6 MDC period", 64'(int'(t2 - t1)), 64'(2 * HALF * 5));
        wait_idle();

        // R5 read frames with two reply patterns
        issue(mk(1, 1, 5'h1F, 5'h00, 16'h0000), 16'hA5C3);
        wait_idle();
        issue(mk(1, 1, 5'h00, 5'h1F, 16'hFFFF), 16'h0001);
        wait_idle();

        // R4 write with all-ones data and extreme addresses
        issue(mk(1, 0, 5'h00, 5'h1F, 16'hFFFF), 16'h0);
        wait_idle();

        // R7 store mid-frame during a read is ignored
        issue(mk(1, 1, 5'h0A, 5'h15, 16'h0000), 16'h8001);
        repeat (100) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();

        // R7 store landing on the completion edge is ignored
        issue(mk(1, 1, 5'h05, 5'h06, 16'h0000), 16'h1234);
        repeat (FRAME_CLKS - 1) @(negedge clk);
        wr_en = 1'b1; wr_data = mk(1, 0, 5'h1E, 5'h1D, 16'h5555);
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        r0 = total_rises;
        repeat (300) @(negedge clk);
        check(rd_data == {1'b0, 15'(mk(0, 1, 5'h05, 5'h06, 16'h0) >> 16), 16'h1234},
              "R7 word after collision", 64'(rd_data),
              64'({1'b0, 15'(mk(0, 1, 5'h05, 5'h06, 16'h0) >> 16), 16'h1234}));
        check(total_rises == r0 && !mdio_oe, "R7 no new frame", 64'(total_rises - r0), 64'h0);

        summary();
        $finish;
    end

endmodule